// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block keeps a 1024-row asynchronous DRAM alive. After reset it stays silent for a power-up delay. It then runs a fixed number of CAS-before-RAS cycles to initialise the part, because the part's own row counter supplies the refresh address. Once initialisation is over, an interval timer adds one refresh credit per refresh period. The block spends the credits as CAS-before-RAS cycles whenever it owns the strobes. The default period of 1560 clocks at 100 MHz spreads 1024 refreshes over 16 ms.

The block shares the strobe pins with an access controller through a request and grant pair. The controller holds its request for as long as it uses the bus, and the grant is never withdrawn while that request stays high. Refresh credits that build up during a long access are postponed. When the bus comes free they are issued back to back, up to a stored limit. If the pending count has reached an urgency level, refresh takes the bus ahead of a new request.

When self refresh is enabled and the bus has been quiet for long enough, the block starts a CAS-before-RAS cycle and keeps both strobes low. The memory then refreshes itself. The block leaves self refresh by raising RAS once a minimum hold time has passed and either a request arrives or the enable drops. After the exit it keeps RAS high for a recovery time before the bus is used again. Every delay is a parameter in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: For PWRUP_CYC cycles after reset is released, `ras_n_o` and `cas_n_o` stay high, `strobe_own_o` and `acc_gnt_o` stay low, and `busy_o` is high.
- R2: After the power-up delay, exactly INIT_CYC CAS-before-RAS cycles are issued while `busy_o` is high. `busy_o` then drops.
- R3: In every CAS-before-RAS cycle, `cas_n_o` goes low while `ras_n_o` is high and stays low with RAS high for CSR_CYC cycles. `ras_n_o` is then low for RAS_CYC cycles with CAS low, and both strobes rise in the same cycle.
- R4: Both strobes are high for at least RP_CYC cycles before any falling edge of `cas_n_o` that the block issues.
- R5: Once initialisation is complete, one refresh credit is added every REF_INTERVAL cycles, except during self refresh. Each credit is spent as one CAS-before-RAS cycle. With the bus idle, the rate of refresh cycles therefore matches the interval.
- R6: Credits saturate at MAX_CREDIT, and `ref_due_o` is high while any credit is pending. When the bus is released, all pending credits are issued back to back, with exactly RP_CYC precharge cycles between one cycle and the next.
- R7: A request on a free bus is granted on the next clock edge unless refresh takes the bus. Refresh takes a free bus when a credit is pending and either no request is present or the credit count is at least URGENT_LVL. A grant lasts as long as the request, and `acc_gnt_o` and `strobe_own_o` are never high together.
- R8: `acc_gnt_o` stays low while `busy_o` is high, even if `acc_req_i` is held high from reset.
- R9: With `sr_en_i` high, no pending credit and the bus quiet for SR_IDLE_CYC cycles, the block enters self refresh. It runs the CAS-before-RAS entry and then holds both strobes low for at least SR_MIN_CYC cycles, with `sref_o` high.
- R10: Self refresh ends by RAS and CAS rising when the minimum hold has passed and either `acc_req_i` is high or `sr_en_i` is low. RAS then stays high for at least SR_EXIT_CYC cycles before a grant or a new cycle.
- R11: During reset, both strobes are high, `busy_o` is high, and `acc_gnt_o`, `strobe_own_o`, `sref_o` and `ref_due_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req_i | input | 1 | Access controller asks for, and holds, the strobe bus |
| sr_en_i | input | 1 | Allows self refresh during quiet periods |
| acc_gnt_o | output | 1 | Bus granted to the access controller |
| ref_due_o | output | 1 | At least one refresh credit is pending |
| busy_o | output | 1 | Power-up wait or initialisation still in progress |
| sref_o | output | 1 | Memory is being held in self refresh |
| strobe_own_o | output | 1 | This block drives the strobes this cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe for both byte lanes, active low |

## Verification
The strobe sequence is registered state decoded to pins. When a cycle starts, CAS falls RP_CYC cycles after the block takes the bus. RAS falls CSR_CYC cycles after CAS, and both strobes rise RAS_CYC cycles after that. A grant appears one edge after the request is seen on a free bus, or one edge after the block releases the strobes. After a self-refresh exit the grant comes SR_EXIT_CYC + 1 cycles after RAS rises. The bench samples every port on the falling clock edge and measures each of these widths and gaps by counting samples, so it never depends on the order of processes at a rising edge. A scoreboard queue holds the expected kind of each strobe episode (refresh cycle or self refresh), and the monitor pops and compares each episode as it finishes.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PRE, SQ_CSET, SQ_RLOW, SQ_TAIL, SQ_SLOW, SQ_SEXIT
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_PWRUP, PH_INIT, PH_RUN
  } phase_e;

  // bits needed to hold the value n
  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // saturating credit update: +inc, -dec, clipped to [0, cap]
  function automatic int unsigned credit_next(input int unsigned cur, input logic inc,
                                              input logic dec, input int unsigned cap);
    int unsigned v;
    v = cur;
    if (inc) v = v + 1;
    if (dec && v != 0) v = v - 1;
    if (v > cap) v = cap;
    return v;
  endfunction

endpackage

// File: rtl/rfs_credit.sv
module rfs_credit
  import rfs_pkg::*;
#(
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned MAX_CREDIT   = 8,
  localparam int unsigned TW  = bits_for(REF_INTERVAL - 1),
  localparam int unsigned CRW = bits_for(MAX_CREDIT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           dec_i,
  input  logic           clr_i,
  output logic           tick_o,
  output logic [CRW-1:0] credit_o
);

  logic [TW-1:0]  timer_q;
  logic [CRW-1:0] credit_q;

  assign tick_o   = en_i && (timer_q == TW'(REF_INTERVAL - 1));
  assign credit_o = credit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
    end else if (!en_i || tick_o) begin
      timer_q <= '0;
    end else begin
      timer_q <= timer_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= '0;
    end else if (clr_i) begin
      credit_q <= '0;
    end else begin
      credit_q <= CRW'(credit_next(int'(credit_q), tick_o, dec_i, MAX_CREDIT));
    end
  end

  p_credit_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= CRW'(MAX_CREDIT));

  p_credit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o && !clr_i |=> credit_q <= $past(credit_q));

endmodule

// File: rtl/rfs_idle.sv
module rfs_idle
  import rfs_pkg::*;
#(
  parameter int unsigned IDLE_CYC = 256,
  localparam int unsigned IW = bits_for(IDLE_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet_i,
  output logic hit_o
);

  logic [IW-1:0] cnt_q;

  assign hit_o = (cnt_q == IW'(IDLE_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!quiet_i) begin
      cnt_q <= '0;
    end else if (!hit_o) begin
      cnt_q <= cnt_q + IW'(1);
    end
  end

  p_idle_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet_i |=> !hit_o);

endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
  import rfs_pkg::*;
#(
  parameter int unsigned RP_CYC      = 3,
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned RAS_CYC     = 5,
  parameter int unsigned SR_MIN_CYC  = 10001,
  parameter int unsigned SR_EXIT_CYC = 9,
  localparam int unsigned MAXC = max2(max2(max2(RP_CYC, CSR_CYC), max2(RAS_CYC, SR_MIN_CYC)),
                                      SR_EXIT_CYC),
  localparam int unsigned CW   = bits_for(MAXC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_cbr_i,
  input  logic go_sref_i,
  input  logic more_i,
  input  logic exit_req_i,
  output logic own_o,
  output logic cbr_done_o,
  output logic in_sref_o,
  output logic ras_n_o,
  output logic cas_n_o
);

  localparam logic [CW-1:0] LD_RP   = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] LD_CSR  = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] LD_RAS  = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] LD_SMIN = CW'(SR_MIN_CYC - 1);
  localparam logic [CW-1:0] LD_SEX  = CW'(SR_EXIT_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sr_mode_q, sr_mode_d;
  logic          cnt_zero;
  logic          sr_min_met;

  assign cnt_zero   = (cnt_q == '0);
  assign sr_min_met = (st_q == SQ_SLOW) && cnt_zero;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_zero ? cnt_q : cnt_q - CW'(1);
    sr_mode_d = sr_mode_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (go_cbr_i) begin
          st_d = SQ_PRE; cnt_d = LD_RP; sr_mode_d = 1'b0;
        end else if (go_sref_i) begin
          st_d = SQ_PRE; cnt_d = LD_RP; sr_mode_d = 1'b1;
        end
      end
      SQ_PRE: if (cnt_zero) begin
        st_d = SQ_CSET; cnt_d = LD_CSR;
      end
      SQ_CSET: if (cnt_zero) begin
        st_d  = sr_mode_q ? SQ_SLOW : SQ_RLOW;
        cnt_d = sr_mode_q ? LD_SMIN : LD_RAS;
      end
      SQ_RLOW: if (cnt_zero) begin
        st_d  = more_i ? SQ_PRE : SQ_TAIL;
        cnt_d = LD_RP;
      end
      SQ_TAIL: if (cnt_zero) st_d = SQ_IDLE;
      SQ_SLOW: if (cnt_zero && exit_req_i) begin
        st_d = SQ_SEXIT; cnt_d = LD_SEX;
      end
      SQ_SEXIT: if (cnt_zero) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      cnt_q     <= '0;
      sr_mode_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      sr_mode_q <= sr_mode_d;
    end
  end

  assign own_o      = (st_q != SQ_IDLE);
  assign cbr_done_o = (st_q == SQ_RLOW) && cnt_zero;
  assign in_sref_o  = (st_q == SQ_SLOW);
  assign ras_n_o    = !((st_q == SQ_RLOW) || (st_q == SQ_SLOW));
  assign cas_n_o    = !((st_q == SQ_CSET) || (st_q == SQ_RLOW) || (st_q == SQ_SLOW));

  // CAS must already be low when RAS falls
  p_cas_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> !cas_n_o && $past(!cas_n_o));

  // both strobes rise together at the end of a low phase
  p_joint_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> $rose(cas_n_o));

  // CAS falls only out of a full precharge with both strobes high
  p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n_o) |-> ras_n_o && $past(ras_n_o && cas_n_o));

  // self refresh is left only after the minimum hold
  p_sr_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) && $past(in_sref_o) |-> $past(sr_min_met));

  // RAS stays high right after a self-refresh exit
  p_exit_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) && $past(in_sref_o) |=> ras_n_o && cas_n_o);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfs_pkg::*;
#(
  parameter int unsigned PWRUP_CYC    = 20000,
  parameter int unsigned INIT_CYC     = 8,
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned MAX_CREDIT   = 8,
  parameter int unsigned URGENT_LVL   = 6,
  parameter int unsigned RP_CYC       = 3,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned RAS_CYC      = 5,
  parameter int unsigned SR_IDLE_CYC  = 256,
  parameter int unsigned SR_MIN_CYC   = 10001,
  parameter int unsigned SR_EXIT_CYC  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req_i,
  input  logic sr_en_i,
  output logic acc_gnt_o,
  output logic ref_due_o,
  output logic busy_o,
  output logic sref_o,
  output logic strobe_own_o,
  output logic ras_n_o,
  output logic cas_n_o
);

  localparam int unsigned PW  = bits_for(PWRUP_CYC);
  localparam int unsigned NW  = bits_for(INIT_CYC);
  localparam int unsigned CRW = bits_for(MAX_CREDIT);

  phase_e         ph_q;
  logic [PW-1:0]  pw_cnt_q;
  logic [NW-1:0]  init_left_q;
  logic           gnt_q;

  logic           own, cbr_done, in_sref;
  logic           tick;
  logic [CRW-1:0] credit;
  logic           idle_hit;

  // named events for checks
  logic run_ph, init_ph, pwrup_end, init_end;
  logic ref_take, init_go, go_cbr, go_sref, more, exit_req, quiet, credit_urgent;

  assign run_ph        = (ph_q == PH_RUN);
  assign init_ph       = (ph_q == PH_INIT);
  assign pwrup_end     = (ph_q == PH_PWRUP) && (pw_cnt_q == PW'(PWRUP_CYC - 1));
  assign init_end      = init_ph && (init_left_q == '0) && !own;
  assign credit_urgent = (credit >= CRW'(URGENT_LVL));
  assign ref_take      = run_ph && !gnt_q && !own && (credit != '0) &&
                         (!acc_req_i || credit_urgent);
  assign init_go       = init_ph && (init_left_q != '0);
  assign go_cbr        = init_go || ref_take;
  assign go_sref       = run_ph && sr_en_i && idle_hit && !acc_req_i && !own &&
                         !gnt_q && (credit == '0);
  assign more          = init_ph ? (init_left_q > NW'(1)) : ((credit > CRW'(1)) || tick);
  assign exit_req      = acc_req_i || !sr_en_i;
  assign quiet         = run_ph && !acc_req_i && !own && !gnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_PWRUP;
      pw_cnt_q    <= '0;
      init_left_q <= NW'(INIT_CYC);
    end else begin
      unique case (ph_q)
        PH_PWRUP: begin
          if (pwrup_end) ph_q <= PH_INIT;
          else           pw_cnt_q <= pw_cnt_q + PW'(1);
        end
        PH_INIT: begin
          if (cbr_done && init_left_q != '0) init_left_q <= init_left_q - NW'(1);
          if (init_end) ph_q <= PH_RUN;
        end
        default: ph_q <= PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= run_ph && acc_req_i && (gnt_q || (!own && !ref_take));
  end

  rfs_credit #(
    .REF_INTERVAL(REF_INTERVAL),
    .MAX_CREDIT  (MAX_CREDIT)
  ) u_credit (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (run_ph && !in_sref),
    .dec_i   (cbr_done && run_ph),
    .clr_i   (in_sref),
    .tick_o  (tick),
    .credit_o(credit)
  );

  rfs_idle #(
    .IDLE_CYC(SR_IDLE_CYC)
  ) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .quiet_i(quiet),
    .hit_o  (idle_hit)
  );

  rfs_seq #(
    .RP_CYC     (RP_CYC),
    .CSR_CYC    (CSR_CYC),
    .RAS_CYC    (RAS_CYC),
    .SR_MIN_CYC (SR_MIN_CYC),
    .SR_EXIT_CYC(SR_EXIT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_cbr_i  (go_cbr),
    .go_sref_i (go_sref),
    .more_i    (more),
    .exit_req_i(exit_req),
    .own_o     (own),
    .cbr_done_o(cbr_done),
    .in_sref_o (in_sref),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o)
  );

  assign acc_gnt_o    = gnt_q;
  assign ref_due_o    = (credit != '0);
  assign busy_o       = !run_ph;
  assign sref_o       = in_sref;
  assign strobe_own_o = own;

  p_pwrup_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PWRUP) |-> ras_n_o && cas_n_o && !own);

  p_no_gnt_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !acc_gnt_o);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_gnt_o && strobe_own_o));

  p_gnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt_o && acc_req_i |=> acc_gnt_o);

  p_init_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(init_left_q == '0));

endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;

  localparam int PWRUP = 50;
  localparam int INITN = 8;
  localparam int RI    = 200;
  localparam int MAXC  = 8;
  localparam int URG   = 6;
  localparam int RP    = 3;
  localparam int CSR   = 1;
  localparam int RASC  = 4;
  localparam int SIDLE = 30;
  localparam int SMIN  = 40;
  localparam int SEXIT = 9;
  localparam int KIND_CBR  = 0;
  localparam int KIND_SREF = 1;

  logic clk = 1'b0;
  logic rst_n, acc_req, sr_en;
  logic acc_gnt, ref_due, busy, sref, own, ras_n, cas_n;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .PWRUP_CYC(PWRUP), .INIT_CYC(INITN), .REF_INTERVAL(RI), .MAX_CREDIT(MAXC),
    .URGENT_LVL(URG), .RP_CYC(RP), .CSR_CYC(CSR), .RAS_CYC(RASC),
    .SR_IDLE_CYC(SIDLE), .SR_MIN_CYC(SMIN), .SR_EXIT_CYC(SEXIT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .acc_req_i(acc_req), .sr_en_i(sr_en),
    .acc_gnt_o(acc_gnt), .ref_due_o(ref_due), .busy_o(busy), .sref_o(sref),
    .strobe_own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n)
  );

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];
  bit extra_ok = 0;
  int cbr_total = 0;
  int init_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures each strobe episode and pops the scoreboard
  int  hi_cnt = 1000, setup_cnt = 0, low_cnt = 0, pre_meas = 0, setup_meas = 0;
  logic pr = 1'b1, pc = 1'b1;

  task automatic close_episode(input int low);
    int kind;
    kind = (low > RASC) ? KIND_SREF : KIND_CBR;
    chk(cas_n == 1'b1, "R3 strobes rise together", int'(cas_n), 1);
    chk(setup_meas == CSR, "R3 CAS-to-RAS lead", setup_meas, CSR);
    chk(pre_meas >= RP, "R4 precharge before CAS", pre_meas, RP);
    if (kind == KIND_CBR) begin
      chk(low == RASC, "R3 RAS low width", low, RASC);
      cbr_total++;
      if (busy) init_seen++;
    end else begin
      chk(low >= SMIN, "R9 self-refresh hold", low, SMIN);
    end
    if (exp_q.size() > 0 && exp_q[0] == kind) begin
      void'(exp_q.pop_front());
      chk(1'b1, "R2 scoreboard match", kind, kind);
    end else if (!(extra_ok && kind == KIND_CBR)) begin
      chk(1'b0, "R5 unexpected strobe episode", kind, -1);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ras_n && !cas_n && pc) begin pre_meas = hi_cnt; setup_cnt = 0; end
      if (!ras_n && pr) begin setup_meas = setup_cnt; low_cnt = 0; end
      if (ras_n && !pr) close_episode(low_cnt);
      if (ras_n && cas_n) hi_cnt++; else hi_cnt = 0;
      if (ras_n && !cas_n) setup_cnt++;
      if (!ras_n) low_cnt++;
      pr = ras_n;
      pc = cas_n;
    end
  end

  initial begin
    int bad, guard, base, n, dur, gap;
    rst_n = 1'b0; acc_req = 1'b1; sr_en = 1'b0;
    for (int i = 0; i < INITN; i++) exp_q.push_back(KIND_CBR);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(ras_n && cas_n, "R11 strobes high in reset", int'({ras_n, cas_n}), 3);
    chk(!acc_gnt && !own && !sref && !ref_due, "R11 outputs low in reset",
        int'({acc_gnt, own, sref, ref_due}), 0);
    chk(busy, "R11 busy in reset", int'(busy), 1);
    rst_n = 1'b1;

    // R1 power-up silence
    bad = 0;
    for (int i = 0; i < PWRUP; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n || own || acc_gnt) bad++;
    end
    chk(bad == 0, "R1 quiet during power-up", bad, 0);
    chk(busy, "R1 busy during power-up", int'(busy), 1);

    // R2 / R8 initialisation with request held
    bad = 0; guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk); guard++;
      if (acc_gnt) bad++;
    end
    chk(bad == 0, "R8 no grant while busy", bad, 0);
    chk(!busy, "R2 busy released", int'(busy), 0);
    chk(init_seen == INITN, "R2 init cycle count", init_seen, INITN);

    // R7 grant after init
    guard = 0;
    while (!acc_gnt && guard < 4) begin @(negedge clk); guard++; end
    chk(acc_gnt, "R7 grant on free bus", int'(acc_gnt), 1);

    // R6 / R7 long access postpones refresh
    bad = 0;
    for (int i = 0; i < 12 * RI; i++) begin
      @(negedge clk);
      if (own || !acc_gnt) bad++;
    end
    chk(bad == 0, "R7 grant held, refresh waits", bad, 0);
    chk(ref_due, "R6 credits pending", int'(ref_due), 1);

    // R7 urgent refresh wins on re-request; R6 burst
    base = cbr_total;
    for (int i = 0; i < MAXC; i++) exp_q.push_back(KIND_CBR);
    extra_ok = 1'b1;
    acc_req = 1'b0;
    @(negedge clk);
    acc_req = 1'b1;
    guard = 0;
    while (!own && guard < 8) begin @(negedge clk); guard++; end
    chk(own, "R7 urgent refresh takes bus", int'(own), 1);
    dur = 0; bad = 0;
    while (own && dur < 1000) begin
      if (acc_gnt) bad++;
      @(negedge clk); dur++;
    end
    n = cbr_total - base;
    chk(bad == 0, "R7 no grant during refresh", bad, 0);
    chk(n >= MAXC && n <= MAXC + 1, "R6 saturated burst count", n, MAXC);
    chk(dur <= (MAXC + 1) * (RP + CSR + RASC) + RP, "R6 back-to-back burst", dur,
        (MAXC + 1) * (RP + CSR + RASC) + RP);
    guard = 0;
    while (!acc_gnt && guard < 4) begin @(negedge clk); guard++; end
    chk(acc_gnt && guard <= 2, "R7 grant after release", guard, 1);

    // R5 periodic refresh with idle bus
    acc_req = 1'b0;
    base = cbr_total;
    repeat (5 * RI) @(negedge clk);
    n = cbr_total - base;
    chk(n >= 4 && n <= 6, "R5 refresh rate", n, 5);

    // R9 / R10 self refresh, exit by request
    exp_q.push_back(KIND_SREF);
    sr_en = 1'b1;
    guard = 0;
    while (!sref && guard < RI + 300) begin @(negedge clk); guard++; end
    chk(sref, "R9 self refresh entered", int'(sref), 1);
    chk(!ras_n && !cas_n, "R9 strobes low in self refresh", int'({ras_n, cas_n}), 0);
    acc_req = 1'b1;
    guard = 0;
    while (!ras_n && guard < SMIN + 100) begin @(negedge clk); guard++; end
    chk(ras_n && !sref, "R10 exit on request", int'({ras_n, sref}), 2);
    gap = 0; bad = 0;
    while (!acc_gnt && gap < 100) begin
      @(negedge clk); gap++;
      if (!ras_n) bad++;
    end
    chk(acc_gnt, "R10 grant after exit", int'(acc_gnt), 1);
    chk(gap >= SEXIT, "R10 RAS-high recovery", gap, SEXIT);
    chk(bad == 0, "R10 RAS stays high", bad, 0);

    // R9 idle wait, R10 exit by disable
    exp_q.push_back(KIND_SREF);
    acc_req = 1'b0;
    guard = 0;
    while (!sref && guard < 500) begin @(negedge clk); guard++; end
    chk(sref && guard >= SIDLE, "R9 entry after idle time", guard, SIDLE);
    sr_en = 1'b0;
    guard = 0;
    while (sref && guard < SMIN + 20) begin @(negedge clk); guard++; end
    chk(!sref && guard <= SMIN + 2, "R10 exit on disable", guard, SMIN);
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog R1-R11: actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule